// File: doc/BRIEF.md
# Stepper Excitation Sequencer

This block produces the per-winding current commands for a two-winding stepping motor. An electrical position counter moves once per rising edge of an internal step clock. A quarter-wave sine lookup, shaped by the selected excitation mode, turns that position into one signed percentage per winding. The supported modes are full-step with both windings energized, half-step at full torque, plain half-step, and microstepping at 256 or 128 divisions per electrical cycle.

A configuration word is captured on a single-cycle load pulse. It sets direction, mode, step freeze, position restart and drive enable. Direction and mode are staged and take effect only on the next step. Freeze, restart and drive enable act at the load itself. When the mode changes, the first step moves to a defined landing position instead of a plain increment. A downstream current chopper would consume the outputs.

Top module: `stp_exc_seq`

## Requirements
- R1: After rst_n the drive is disabled (coil_hiz=1, coil_a=coil_b=0), the staged and active mode are full-step, direction is forward, and the position is 896. Enabling the drive without stepping then gives coil_a=+100, coil_b=-100.
- R2: cfg_mode selects the mode as follows: 00 full-step, 01 half-step full torque, 10 plain half-step, 11 microstep. Within microstep, cfg_fine=1 selects 128 divisions and 0 selects 256. In full-step each step moves the position by 256, and both windings are always +100 or -100.
- R3: Half-step full torque moves by 128 per step. Each winding is 0 where the plain sine value is 0, and otherwise carries the sine's sign at magnitude 100.
- R4: Plain half-step moves by 128 per step and outputs the plain sine values, so the diagonal positions give magnitude 71.
- R5: Microstep moves by 4 (256 divisions) or 8 (128 divisions) per step. The position p lies in 0..1023 with angle p*90/256 degrees. coil_a = round(100*cos) and coil_b = round(100*sin), and no output exceeds magnitude 100.
- R6: With cfg_dir_ccw=0 the position increases, so coil_b lags coil_a by 90 degrees. With 1 it decreases, so coil_b leads.
- R7: Mode and direction captured at a load have no effect on the outputs until the next step.
- R8: On the first step into either half-step mode from another mode, the position goes to the diagonal (offset 128) of its current quarter. If it is already there, it advances normally instead.
- R9: On the first step into full-step, the position goes to its quarter's diagonal unconditionally. On the first step into microstep, it goes to the position aligned down to the new step size, plus or minus one step.
- R10: A step is a rising edge of the internal clock. While not frozen, the internal clock follows step_clk. A load with cfg_hold=1 freezes the internal clock at the level step_clk has at that load, and no step occurs while frozen. A rise created by the release counts as a step.
- R11: A load with cfg_restart=1 sets the position to the initial position of the loaded mode and makes that mode active. The initial position is 896 for full-step and 0 otherwise. The position then stays fixed until a load clears cfg_restart, after which the next internal rise steps.
- R12: A load with cfg_drive_en=0 gives coil_hiz=1 and zero outputs while the position keeps stepping. Re-enabling shows the position reached in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_clk | input | 1 | External step clock, sampled on clk |
| cfg_load | input | 1 | Single-cycle configuration capture pulse |
| cfg_dir_ccw | input | 1 | Direction: 1 reverse |
| cfg_hold | input | 1 | Freeze the internal step clock |
| cfg_restart | input | 1 | Force and hold the initial position |
| cfg_drive_en | input | 1 | Drive enable; 0 gives high impedance |
| cfg_mode | input | 2 | Excitation mode selection |
| cfg_fine | input | 1 | Microstep division select: 1 means 128 |
| coil_a | output | 8 | Signed winding A current percent |
| coil_b | output | 8 | Signed winding B current percent |
| coil_hiz | output | 1 | Outputs in high impedance |

## Verification
The bound checks run on every cycle. They cover zero outputs under high impedance, the amplitude sets allowed in full-step and full-torque half-step, the magnitude bound, and the position staying fixed while frozen or held in restart. Other behaviour only shows up as a sequence of events, so the bench scenarios must produce it. This covers the mode-change landing positions, whether a release of the freeze counts as a step, the deferral of mode and direction to the next step, and the position reached while the drive was off.

// File: rtl/stp_pkg.sv
package stp_pkg;
  typedef enum logic [2:0] {
    EXC_FULL      = 3'd0,
    EXC_HALF_FT   = 3'd1,
    EXC_HALF      = 3'd2,
    EXC_MICRO_256 = 3'd3,
    EXC_MICRO_128 = 3'd4
  } exc_mode_e;

  localparam int TBL_BITS = 6;
  localparam int TBL_N    = (1 << TBL_BITS) + 1;
  localparam int AMP_MAX  = 100;

  function automatic exc_mode_e decode_mode(input logic [1:0] sel, input logic fine);
    exc_mode_e m;
    case (sel)
      2'b00:   m = EXC_FULL;
      2'b01:   m = EXC_HALF_FT;
      2'b10:   m = EXC_HALF;
      default: m = fine ? EXC_MICRO_128 : EXC_MICRO_256;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/stp_clkgate.sv
module stp_clkgate (
  input  logic clk,
  input  logic rst_n,
  input  logic step_clk,
  input  logic load,
  input  logic hold_cfg,
  output logic hold_q,
  output logic step_rise
);
  logic held_q, held_d, hold_d;
  logic int_q, int_d;

  always_comb begin
    hold_d = hold_q;
    held_d = held_q;
    if (load) begin
      hold_d = hold_cfg;
      if (hold_cfg && !hold_q) held_d = step_clk;
    end
    int_d = hold_q ? held_q : step_clk;
  end

  assign step_rise = int_d & ~int_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      held_q <= 1'b0;
      int_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      held_q <= held_d;
      int_q  <= int_d;
    end
  end
endmodule

// File: rtl/stp_poscnt.sv
module stp_poscnt
  import stp_pkg::*;
#(
  parameter int POS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  exc_mode_e        restart_mode,
  input  logic             step,
  input  exc_mode_e        step_mode,
  input  logic             step_ccw,
  output logic [POS_W-1:0] pos_q,
  output exc_mode_e        mode_q
);
  localparam int QTR_W = POS_W - 2;
  localparam logic [POS_W-1:0] ONE       = {{(POS_W-1){1'b0}}, 1'b1};
  localparam logic [POS_W-1:0] INC_FULL  = ONE << (POS_W - 2);
  localparam logic [POS_W-1:0] INC_HALF  = ONE << (POS_W - 3);
  localparam logic [POS_W-1:0] INC_M128  = ONE << (POS_W - 7);
  localparam logic [POS_W-1:0] INC_M256  = ONE << (POS_W - 8);
  localparam logic [POS_W-1:0] INIT_FULL = {2'b11, 1'b1, {(QTR_W-1){1'b0}}};

  function automatic logic [POS_W-1:0] inc_of(input exc_mode_e m);
    logic [POS_W-1:0] v;
    case (m)
      EXC_FULL:      v = INC_FULL;
      EXC_HALF_FT,
      EXC_HALF:      v = INC_HALF;
      EXC_MICRO_128: v = INC_M128;
      default:       v = INC_M256;
    endcase
    return v;
  endfunction

  logic [POS_W-1:0] inc, diag, base, pos_d, adv;
  exc_mode_e        mode_d;

  always_comb begin
    inc  = inc_of(step_mode);
    diag = {pos_q[POS_W-1 -: 2], 1'b1, {(QTR_W-1){1'b0}}};
    base = pos_q & ~(inc - ONE);
    if (step_mode != mode_q) begin
      case (step_mode)
        EXC_FULL:    adv = diag;
        EXC_HALF_FT,
        EXC_HALF:    adv = (pos_q == diag) ? (step_ccw ? pos_q - inc : pos_q + inc) : diag;
        default:     adv = step_ccw ? base - inc : base + inc;
      endcase
    end else begin
      adv = step_ccw ? pos_q - inc : pos_q + inc;
    end

    pos_d  = pos_q;
    mode_d = mode_q;
    if (restart) begin
      pos_d  = (restart_mode == EXC_FULL) ? INIT_FULL : '0;
      mode_d = restart_mode;
    end else if (step) begin
      pos_d  = adv;
      mode_d = step_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= INIT_FULL;
      mode_q <= EXC_FULL;
    end else begin
      pos_q  <= pos_d;
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/stp_phase_map.sv
module stp_phase_map
  import stp_pkg::*;
#(
  parameter int POS_W = 10
) (
  input  logic [POS_W-1:0]  pos,
  input  exc_mode_e         mode,
  output logic signed [7:0] ph_a,
  output logic signed [7:0] ph_b
);
  localparam int QTR_W = POS_W - 2;
  localparam real PI   = 3.14159265358979;

  logic [6:0] rom [TBL_N];

  for (genvar i = 0; i < TBL_N; i++) begin : g_rom
    localparam int VAL =
      int'($floor(real'(AMP_MAX) * $sin(PI * real'(i) / (2.0 * real'(TBL_N - 1))) + 0.5));
    assign rom[i] = 7'(VAL);
  end

  logic [1:0] quad;
  logic [6:0] idx_lo, idx_hi;
  logic [6:0] mag_sin, mag_cos, sh_sin, sh_cos;
  logic       neg_sin, neg_cos, square;

  always_comb begin
    quad    = pos[POS_W-1 -: 2];
    idx_lo  = {1'b0, pos[QTR_W-1 -: TBL_BITS]};
    idx_hi  = 7'(TBL_N - 1) - idx_lo;
    mag_sin = quad[0] ? rom[idx_hi] : rom[idx_lo];
    mag_cos = quad[0] ? rom[idx_lo] : rom[idx_hi];
    neg_sin = quad[1];
    neg_cos = quad[0] ^ quad[1];
    square  = (mode == EXC_FULL) || (mode == EXC_HALF_FT);
    sh_sin  = (square && mag_sin != 7'd0) ? 7'(AMP_MAX) : mag_sin;
    sh_cos  = (square && mag_cos != 7'd0) ? 7'(AMP_MAX) : mag_cos;
    ph_a    = neg_cos ? -$signed({1'b0, sh_cos}) : $signed({1'b0, sh_cos});
    ph_b    = neg_sin ? -$signed({1'b0, sh_sin}) : $signed({1'b0, sh_sin});
  end
endmodule

// File: rtl/stp_exc_seq.sv
module stp_exc_seq
  import stp_pkg::*;
#(
  parameter int POS_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_clk,
  input  logic              cfg_load,
  input  logic              cfg_dir_ccw,
  input  logic              cfg_hold,
  input  logic              cfg_restart,
  input  logic              cfg_drive_en,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_fine,
  output logic signed [7:0] coil_a,
  output logic signed [7:0] coil_b,
  output logic              coil_hiz
);
  exc_mode_e        pend_mode_q, pend_mode_d, act_mode, load_mode;
  logic             dir_q, dir_d, clr_q, clr_d, oe_q, oe_d;
  logic             hold_q, step_rise;
  logic [POS_W-1:0] pos_q;
  logic signed [7:0] ph_a, ph_b;

  assign load_mode = decode_mode(cfg_mode, cfg_fine);

  always_comb begin
    pend_mode_d = pend_mode_q;
    dir_d       = dir_q;
    clr_d       = clr_q;
    oe_d        = oe_q;
    if (cfg_load) begin
      pend_mode_d = load_mode;
      dir_d       = cfg_dir_ccw;
      clr_d       = cfg_restart;
      oe_d        = cfg_drive_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_mode_q <= EXC_FULL;
      dir_q       <= 1'b0;
      clr_q       <= 1'b0;
      oe_q        <= 1'b0;
    end else begin
      pend_mode_q <= pend_mode_d;
      dir_q       <= dir_d;
      clr_q       <= clr_d;
      oe_q        <= oe_d;
    end
  end

  stp_clkgate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_clk  (step_clk),
    .load      (cfg_load),
    .hold_cfg  (cfg_hold),
    .hold_q    (hold_q),
    .step_rise (step_rise)
  );

  stp_poscnt #(.POS_W(POS_W)) u_pos (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (cfg_load & cfg_restart),
    .restart_mode (load_mode),
    .step         (step_rise & ~clr_q),
    .step_mode    (pend_mode_q),
    .step_ccw     (dir_q),
    .pos_q        (pos_q),
    .mode_q       (act_mode)
  );

  stp_phase_map #(.POS_W(POS_W)) u_map (
    .pos  (pos_q),
    .mode (act_mode),
    .ph_a (ph_a),
    .ph_b (ph_b)
  );

  assign coil_hiz = ~oe_q;
  assign coil_a   = oe_q ? ph_a : 8'sd0;
  assign coil_b   = oe_q ? ph_b : 8'sd0;
endmodule

// File: rtl/stp_exc_seq_chk.sv
module stp_exc_seq_chk
  import stp_pkg::*;
#(
  parameter int POS_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic signed [7:0] coil_a,
  input logic signed [7:0] coil_b,
  input logic              coil_hiz,
  input logic [POS_W-1:0]  pos_q,
  input exc_mode_e         act_mode,
  input logic              hold_q,
  input logic              clr_q
);
  assert_hiz_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    coil_hiz |-> (coil_a == 8'sd0 && coil_b == 8'sd0));

  assert_full_square_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!coil_hiz && act_mode == EXC_FULL) |->
      ((coil_a == 8'sd100 || coil_a == -8'sd100) && (coil_b == 8'sd100 || coil_b == -8'sd100)));

  assert_ft_levels_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!coil_hiz && act_mode == EXC_HALF_FT) |->
      ((coil_a == 8'sd0 || coil_a == 8'sd100 || coil_a == -8'sd100) &&
       (coil_b == 8'sd0 || coil_b == 8'sd100 || coil_b == -8'sd100)));

  assert_amp_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (coil_a <= 8'sd100 && coil_a >= -8'sd100 && coil_b <= 8'sd100 && coil_b >= -8'sd100));

  assert_hold_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !cfg_load) |=> $stable(pos_q));

  assert_restart_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && !cfg_load) |=> $stable(pos_q));
endmodule

bind stp_exc_seq stp_exc_seq_chk #(.POS_W(POS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_load (cfg_load),
  .coil_a   (coil_a),
  .coil_b   (coil_b),
  .coil_hiz (coil_hiz),
  .pos_q    (pos_q),
  .act_mode (act_mode),
  .hold_q   (hold_q),
  .clr_q    (clr_q)
);

// File: tb/sim_stp_exc_seq.sv
`timescale 1ns/1ps
module sim_stp_exc_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_clk = 1'b0;
  logic cfg_load = 1'b0, cfg_dir_ccw = 1'b0, cfg_hold = 1'b0, cfg_restart = 1'b0;
  logic cfg_drive_en = 1'b0, cfg_fine = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic signed [7:0] coil_a, coil_b;
  logic coil_hiz;

  int vectors = 0;
  int fails = 0;
  string tag = "R1";

  // model state
  int m_pos = 896, m_act = 0, m_pend = 0;
  bit m_dir = 0, m_hold = 0, m_held = 0, m_intq = 0, m_clr = 0, m_oe = 0;

  always #10 clk = ~clk;

  stp_exc_seq u0 (
    .clk(clk), .rst_n(rst_n), .step_clk(step_clk), .cfg_load(cfg_load),
    .cfg_dir_ccw(cfg_dir_ccw), .cfg_hold(cfg_hold), .cfg_restart(cfg_restart),
    .cfg_drive_en(cfg_drive_en), .cfg_mode(cfg_mode), .cfg_fine(cfg_fine),
    .coil_a(coil_a), .coil_b(coil_b), .coil_hiz(coil_hiz)
  );

  function automatic int wrap(int x);
    return ((x % 1024) + 1024) % 1024;
  endfunction

  function automatic int mode_of(logic [1:0] sel, logic fine);
    if (sel == 2'b11) return fine ? 4 : 3;
    return int'(sel);
  endfunction

  function automatic int step_size(int m);
    case (m)
      0: return 256;
      1, 2: return 128;
      3: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic int next_pos(int p, int mn, int mo, bit ccw);
    int s = step_size(mn);
    int d = (p / 256) * 256 + 128;
    int b = p - (p % s);
    if (mn == mo) return wrap(ccw ? p - s : p + s);
    if (mn == 0) return d;
    if (mn == 1 || mn == 2) return (p == d) ? wrap(ccw ? p - s : p + s) : d;
    return wrap(ccw ? b - s : b + s);
  endfunction

  function automatic int amp(int p, int m, bit use_sin);
    real th = real'(p) * 3.14159265358979 / 512.0;
    real v = use_sin ? $sin(th) : $cos(th);
    int r = int'($floor(100.0 * v + 0.5));
    if (m == 0 || m == 1) r = (r > 0) ? 100 : ((r < 0) ? -100 : 0);
    return r;
  endfunction

  task automatic model_edge();
    bit int_d = m_hold ? m_held : step_clk;
    bit rise = int_d && !m_intq;
    int lm = mode_of(cfg_mode, cfg_fine);
    if (cfg_load && cfg_restart) begin
      m_pos = (lm == 0) ? 896 : 0;
      m_act = lm;
    end else if (rise && !m_clr) begin
      m_pos = next_pos(m_pos, m_pend, m_act, m_dir);
      m_act = m_pend;
    end
    m_intq = int_d;
    if (cfg_load) begin
      if (cfg_hold && !m_hold) m_held = step_clk;
      m_hold = cfg_hold;
      m_clr  = cfg_restart;
      m_oe   = cfg_drive_en;
      m_dir  = cfg_dir_ccw;
      m_pend = lm;
    end
  endtask

  task automatic check_out();
    int ea = m_oe ? amp(m_pos, m_act, 0) : 0;
    int eb = m_oe ? amp(m_pos, m_act, 1) : 0;
    bit eh = !m_oe;
    vectors++;
    if (int'(coil_a) != ea || int'(coil_b) != eb || coil_hiz != eh) begin
      fails++;
      $display("FAIL %s: a=%0d b=%0d hiz=%0d expected a=%0d b=%0d hiz=%0d",
               tag, coil_a, coil_b, coil_hiz, ea, eb, eh);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_out();
  endtask

  task automatic do_load(logic [1:0] sel, bit fine, bit ccw, bit hold, bit clr, bit en);
    cfg_mode = sel; cfg_fine = fine; cfg_dir_ccw = ccw;
    cfg_hold = hold; cfg_restart = clr; cfg_drive_en = en;
    cfg_load = 1'b1;
    cycle();
    cfg_load = 1'b0;
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      step_clk = 1'b1; cycle();
      step_clk = 1'b0; cycle();
    end
  endtask

  task automatic hard_check(string t, int ea, int eb);
    vectors++;
    if (int'(coil_a) != ea || int'(coil_b) != eb) begin
      fails++;
      $display("FAIL %s: a=%0d b=%0d expected a=%0d b=%0d", t, coil_a, coil_b, ea, eb);
    end
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1 reset state";
    check_out();
    do_load(2'b00, 0, 0, 0, 0, 1);
    hard_check("R1 enable at initial position", 100, -100);

    tag = "R2 full-step sequence";      pulse(4);
    tag = "R7 deferred mode";           do_load(2'b01, 0, 0, 0, 0, 1); cycle();
    tag = "R8 into half-step at diagonal"; pulse(1);
    tag = "R3 full torque half-step";   pulse(5);
    tag = "R8 into plain half-step";    do_load(2'b10, 0, 0, 0, 0, 1); pulse(1);
    tag = "R4 plain half-step";         pulse(6);
    tag = "R9 into microstep 256";      do_load(2'b11, 0, 0, 0, 0, 1); pulse(1);
    tag = "R5 microstep 256";           pulse(40);
    tag = "R9 into microstep 128";      do_load(2'b11, 1, 0, 0, 0, 1); pulse(1);
    tag = "R5 microstep 128";           pulse(30);
    tag = "R6 reverse direction";       do_load(2'b11, 1, 1, 0, 0, 1); pulse(50);
    tag = "R9 into full-step";          do_load(2'b00, 0, 1, 0, 0, 1); pulse(3);

    tag = "R10 freeze high";
    step_clk = 1'b1; cycle();
    do_load(2'b00, 0, 0, 1, 0, 1);
    step_clk = 1'b0; cycle(); pulse(3);
    tag = "R10 release rise";
    do_load(2'b00, 0, 0, 0, 0, 1); pulse(1);
    tag = "R10 freeze low";
    do_load(2'b10, 0, 0, 1, 0, 1);
    step_clk = 1'b1; cycle();
    tag = "R10 release while high";
    do_load(2'b10, 0, 0, 0, 0, 1); cycle();
    step_clk = 1'b0; cycle(); pulse(2);

    tag = "R11 restart";
    do_load(2'b11, 0, 0, 0, 1, 1); pulse(4);
    hard_check("R11 microstep initial", 100, 0);
    do_load(2'b11, 0, 0, 0, 0, 1); pulse(3);

    tag = "R12 drive off";
    do_load(2'b11, 0, 0, 0, 0, 0); pulse(20);
    tag = "R12 drive on";
    do_load(2'b11, 0, 0, 0, 0, 1); cycle();

    tag = "R2 R5 R6 R8 R9 random";
    for (int it = 0; it < 6000; it++) begin
      int r = $urandom % 16;
      if (r < 2) begin
        int k = $urandom % 8;
        do_load(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
                k == 0, k == 1, k != 2);
      end else begin
        step_clk = ~step_clk;
        cycle();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule